// File: doc/BRIEF.md
# Shared Thread Run and Doorbell Status Unit

This unit sits beside a multithreaded core of up to eight hardware threads. It holds the register state that the threads of one core share. Each thread reaches it through one request port tagged with its thread number. A request picks one of three registers: a run-control word, a doorbell summary word, or a facility-control word.

The run-control word has a private copy per thread. A thread writes its own run flag at bit 0. The same write places that flag at bit 8 plus the writer's thread number in the copy of every thread, so each thread can see which of its siblings are running. The doorbell summary holds one pending doorbell flag per thread. It can be read and written as a whole vector, or, when the core runs one partition per thread, as a single flag for the thread that asks. Access to the doorbell summary is guarded by an enable bit in the facility-control word or by hypervisor state. A guarded access that is refused changes nothing. It clears the cause field of the facility-control word and sends a one-cycle exception request with a cause code to the exception logic.

Top module: `core_shared_status`

## Requirements
- R1: After reset, every run-control copy, every doorbell flag and the facility-control word are zero, and `rsp_valid` and `exc_req` are low.
- R2: A run-control write (`req_sel`=0) with `single_thread` low sets bit 0 of the writer's copy to `req_wdata[0]` and leaves the writer's other bits unchanged, apart from the broadcast bit of R3.
- R3: The same write sets bit 8+`req_tid` of every thread's copy to `req_wdata[0]` and leaves all other bits of the other copies unchanged.
- R4: A run-control write with `single_thread` high stores all 16 bits of `req_wdata` into the writer's copy only.
- R5: Every read returns its data on `rsp_data`, with `rsp_valid` high, in the cycle after the request edge. A run-control read returns the reader's own copy.
- R6: A doorbell summary read (`req_sel`=1) with `single_thread` low returns bit i = pending flag of thread i, and bits at or above NUM_THREADS read as zero.
- R7: With `single_thread` high, a doorbell read returns only the reader's flag at bit 0, with all other bits zero, and a doorbell write sets only the writer's flag, from `req_wdata[0]`.
- R8: A doorbell write with `single_thread` low sets the flag of each thread i from `req_wdata[i]`.
- R9: A doorbell access is allowed only when bit 0 of the facility-control word is 1 or `req_hv` is 1. A refused access changes no doorbell flag, reads back zero, and clears bits 15:8 of the facility-control word.
- R10: A high `db_set[i]` makes thread i's flag 1 at that edge. It takes priority over a doorbell write in the same cycle that would clear the flag.
- R11: The facility-control word (`req_sel`=2) is read and written as a whole 16-bit value. Code 3 reads zero and ignores writes.
- R12: Each refused doorbell access raises `exc_req` for exactly the following cycle, with `exc_cause` equal to the DB_CAUSE parameter (default 8'h05) while `exc_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 2 | 0 run-control, 1 doorbell summary, 2 facility-control, 3 none |
| req_tid | input | TID_W | Thread number of the requester |
| req_wdata | input | 16 | Write data |
| req_hv | input | 1 | Requester is in hypervisor state |
| single_thread | input | 1 | One-partition-per-thread mode |
| db_set | input | NUM_THREADS | Doorbell arrival, one bit per thread |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 16 | Read data |
| db_pending | output | NUM_THREADS | Current doorbell flags |
| exc_req | output | 1 | Facility-unavailable exception request pulse |
| exc_cause | output | 8 | Cause code that goes with `exc_req` |

## Verification
Two functions can act on the same doorbell flag in the same cycle: a doorbell arrival on `db_set` and a summary write that clears that flag. The bench drives an arrival for one thread together with an all-zero summary write. It expects the arriving thread's flag to read back as 1 and every other flag as 0. A refused access is also combined with a pending arrival, which checks that the arrival still takes effect while the write is suppressed.

// File: rtl/core_shared_pkg.sv
package core_shared_pkg;
  localparam int REG_W       = 16;
  localparam int MAX_THREADS = 8;

  typedef enum logic [1:0] {
    SEL_RUN  = 2'd0,
    SEL_DB   = 2'd1,
    SEL_FAC  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // position of a thread's broadcast run flag: 8 + tid
  function automatic logic [3:0] run_bit_pos(input logic [2:0] tid);
    return {1'b1, tid};
  endfunction

  // gather doorbell flags into the summary view
  function automatic logic [REG_W-1:0] db_gather(input logic [MAX_THREADS-1:0] pend,
                                                 input logic st,
                                                 input logic [2:0] tid);
    logic [REG_W-1:0] r;
    r = '0;
    if (st) r[0] = pend[tid];
    else    r[MAX_THREADS-1:0] = pend;
    return r;
  endfunction

  // scatter a summary write back onto the per-thread flags
  function automatic logic [MAX_THREADS-1:0] db_scatter(input logic [MAX_THREADS-1:0] cur,
                                                        input logic [REG_W-1:0] w,
                                                        input logic st,
                                                        input logic [2:0] tid);
    logic [MAX_THREADS-1:0] r;
    r = cur;
    if (st) r[tid] = w[0];
    else    r = w[MAX_THREADS-1:0];
    return r;
  endfunction
endpackage

// File: rtl/core_run_ctrl.sv
module core_run_ctrl
  import core_shared_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int TID_W       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             st_mode,
  input  logic [TID_W-1:0] tid,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rd_data
);
  logic [REG_W-1:0] ctrl_q [NUM_THREADS];
  logic [3:0]       bpos;

  assign bpos    = run_bit_pos(3'(tid));
  assign rd_data = ctrl_q[tid];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_THREADS; s++) ctrl_q[s] <= '0;
    end else if (wr_en) begin
      if (st_mode) begin
        ctrl_q[tid] <= wdata;
      end else begin
        for (int s = 0; s < NUM_THREADS; s++) ctrl_q[s][bpos] <= wdata[0];
        ctrl_q[tid][0] <= wdata[0];
      end
    end
  end

  // column of broadcast flags for each thread, checked after its own write
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_col
    logic [NUM_THREADS-1:0] col;
    for (genvar s = 0; s < NUM_THREADS; s++) begin : g_row
      assign col[s] = ctrl_q[s][8+t];
    end

    assert_own_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !st_mode && tid == TID_W'(t)) |=> (ctrl_q[t][0] == $past(wdata[0])));

    assert_broadcast_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !st_mode && tid == TID_W'(t)) |=> (col == {NUM_THREADS{$past(wdata[0])}}));

    assert_st_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && st_mode && tid == TID_W'(t)) |=> (ctrl_q[t] == $past(wdata)));
  end
endmodule

// File: rtl/core_doorbell.sv
module core_doorbell
  import core_shared_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int TID_W       = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   st_mode,
  input  logic [TID_W-1:0]       tid,
  input  logic [REG_W-1:0]       wdata,
  input  logic [NUM_THREADS-1:0] db_set,
  output logic [NUM_THREADS-1:0] pend_o,
  output logic [REG_W-1:0]       rd_data
);
  logic [NUM_THREADS-1:0] pend_q, pend_d;
  logic [MAX_THREADS-1:0] pend_wide, wr_wide;

  always_comb begin
    pend_wide = '0;
    for (int i = 0; i < NUM_THREADS; i++) pend_wide[i] = pend_q[i];
  end

  assign rd_data = db_gather(pend_wide, st_mode, 3'(tid));

  always_comb begin
    wr_wide = pend_wide;
    if (wr_en) wr_wide = db_scatter(pend_wide, wdata, st_mode, 3'(tid));
    // arrivals win over a clearing write
    pend_d = wr_wide[NUM_THREADS-1:0] | db_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  for (genvar i = 0; i < NUM_THREADS; i++) begin : g_chk
    assert_arrival_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      db_set[i] |=> pend_q[i]);
  end

  assert_quiet_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && db_set == '0) |=> $stable(pend_q));

  assert_mt_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !st_mode && db_set == '0) |=> (pend_q == $past(wdata[NUM_THREADS-1:0])));
endmodule

// File: rtl/core_fac_gate.sv
module core_fac_gate
  import core_shared_pkg::*;
#(
  parameter logic [7:0] DB_CAUSE = 8'h05
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             db_access,
  input  logic             hv,
  input  logic             fac_wr,
  input  logic [REG_W-1:0] wdata,
  output logic             allow,
  output logic [REG_W-1:0] fac_q,
  output logic             exc_req,
  output logic [7:0]       exc_cause
);
  localparam int EN_BIT = 0;

  logic deny;

  assign allow = hv | fac_q[EN_BIT];
  assign deny  = db_access & ~allow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fac_q     <= '0;
      exc_req   <= 1'b0;
      exc_cause <= '0;
    end else begin
      if (deny)        fac_q[15:8] <= '0;
      else if (fac_wr) fac_q       <= wdata;
      exc_req   <= deny;
      exc_cause <= deny ? DB_CAUSE : 8'h00;
    end
  end

  assert_cause_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (fac_q[15:8] == 8'h00));

  assert_exc_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (exc_cause == DB_CAUSE));

  assert_exc_needs_access_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !db_access |=> !exc_req);
endmodule

// File: rtl/core_shared_status.sv
module core_shared_status
  import core_shared_pkg::*;
#(
  parameter int         NUM_THREADS = 4,
  parameter int         TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  parameter logic [7:0] DB_CAUSE    = 8'h05
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [1:0]             req_sel,
  input  logic [TID_W-1:0]       req_tid,
  input  logic [15:0]            req_wdata,
  input  logic                   req_hv,
  input  logic                   single_thread,
  input  logic [NUM_THREADS-1:0] db_set,
  output logic                   rsp_valid,
  output logic [15:0]            rsp_data,
  output logic [NUM_THREADS-1:0] db_pending,
  output logic                   exc_req,
  output logic [7:0]             exc_cause
);
  reg_sel_e         sel;
  logic             tid_ok, acc, run_wr, db_acc, db_wr, fac_wr, allow;
  logic [REG_W-1:0] run_rd, db_rd, fac_q, rd_mux;
  logic             rsp_db_q, rsp_st_q;

  assign sel    = reg_sel_e'(req_sel);
  assign tid_ok = (int'(req_tid) < NUM_THREADS);
  assign acc    = req_valid & tid_ok;
  assign run_wr = acc & req_write & (sel == SEL_RUN);
  assign db_acc = acc & (sel == SEL_DB);
  assign db_wr  = db_acc & req_write & allow;
  assign fac_wr = acc & req_write & (sel == SEL_FAC);

  core_run_ctrl #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_run (
    .clk(clk), .rst_n(rst_n), .wr_en(run_wr), .st_mode(single_thread),
    .tid(req_tid), .wdata(req_wdata), .rd_data(run_rd)
  );

  core_doorbell #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_db (
    .clk(clk), .rst_n(rst_n), .wr_en(db_wr), .st_mode(single_thread),
    .tid(req_tid), .wdata(req_wdata), .db_set(db_set),
    .pend_o(db_pending), .rd_data(db_rd)
  );

  core_fac_gate #(.DB_CAUSE(DB_CAUSE)) u_fac (
    .clk(clk), .rst_n(rst_n), .db_access(db_acc), .hv(req_hv),
    .fac_wr(fac_wr), .wdata(req_wdata), .allow(allow), .fac_q(fac_q),
    .exc_req(exc_req), .exc_cause(exc_cause)
  );

  always_comb begin
    rd_mux = '0;
    if (tid_ok) begin
      unique case (sel)
        SEL_RUN:  rd_mux = run_rd;
        SEL_DB:   rd_mux = allow ? db_rd : '0;
        SEL_FAC:  rd_mux = fac_q;
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_db_q  <= 1'b0;
      rsp_st_q  <= 1'b0;
    end else begin
      rsp_valid <= req_valid & ~req_write;
      rsp_data  <= rd_mux;
      rsp_db_q  <= req_valid & ~req_write & (sel == SEL_DB);
      rsp_st_q  <= single_thread;
    end
  end

  assert_db_high_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_db_q) |-> (rsp_data[REG_W-1:NUM_THREADS] == '0));

  assert_db_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_db_q && rsp_st_q) |-> (rsp_data[REG_W-1:1] == '0));

  assert_rsp_follows_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  assert_none_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && sel == SEL_NONE && db_set == '0) |=> ($stable(db_pending) && $stable(fac_q)));
endmodule

// File: tb/core_shared_status_tb.sv
module core_shared_status_tb;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_hv, single_thread;
  logic [1:0]  req_sel;
  logic [1:0]  req_tid;
  logic [15:0] req_wdata;
  logic [N-1:0] db_set;
  logic        rsp_valid, exc_req;
  logic [15:0] rsp_data;
  logic [N-1:0] db_pending;
  logic [7:0]  exc_cause;

  int checks = 0;
  int fails  = 0;

  logic [15:0] ctrl_m [N];
  logic [N-1:0] pend_m;
  logic [15:0] fac_m;

  always #10 clk = ~clk;

  core_shared_status #(.NUM_THREADS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_sel(req_sel), .req_tid(req_tid), .req_wdata(req_wdata), .req_hv(req_hv),
    .single_thread(single_thread), .db_set(db_set), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .db_pending(db_pending), .exc_req(exc_req), .exc_cause(exc_cause)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [1:0] sel, input int tid,
                        input logic [15:0] wd, input bit hv, input bit st,
                        input logic [N-1:0] dbs, input string tag);
    logic [15:0] exp_rd;
    bit allow, exp_exc;
    allow   = hv || fac_m[0];
    exp_exc = (sel == 2'd1) && !allow;
    case (sel)
      2'd0: exp_rd = ctrl_m[tid];
      2'd1: exp_rd = !allow ? 16'h0 : (st ? {15'h0, pend_m[tid]} : {12'h0, pend_m});
      2'd2: exp_rd = fac_m;
      default: exp_rd = 16'h0;
    endcase
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_sel = sel; req_tid = 2'(tid);
    req_wdata = wd; req_hv = hv; single_thread = st; db_set = dbs;
    @(posedge clk);
    #1;
    req_valid = 1'b0; db_set = '0;
    if (wr) begin
      if (sel == 2'd0) begin
        if (st) ctrl_m[tid] = wd;
        else begin
          ctrl_m[tid][0] = wd[0];
          for (int s = 0; s < N; s++) ctrl_m[s][8+tid] = wd[0];
        end
      end else if (sel == 2'd1 && allow) begin
        if (st) pend_m[tid] = wd[0];
        else    pend_m = wd[N-1:0];
      end else if (sel == 2'd2) begin
        fac_m = wd;
      end
    end
    if (exp_exc) fac_m[15:8] = 8'h00;
    pend_m = pend_m | dbs;
    if (!wr) chk(rsp_valid && rsp_data == exp_rd, {tag, " read"}, {15'h0, rsp_valid, rsp_data}, {16'h1, exp_rd});
    chk(exc_req == exp_exc, {tag, " R12 exc_req"}, 32'(exc_req), 32'(exp_exc));
    if (exp_exc) chk(exc_cause == 8'h05, {tag, " R12 exc_cause"}, 32'(exc_cause), 32'h05);
    chk(db_pending == pend_m, {tag, " pending"}, 32'(db_pending), 32'(pend_m));
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    @(posedge clk);
    #1;
    chk(!exc_req && !rsp_valid, {tag, " R12 pulse ends"}, {30'h0, rsp_valid, exc_req}, 32'h0);
  endtask

  task automatic read_all_run(input bit st, input string tag);
    for (int t = 0; t < N; t++) access(1'b0, 2'd0, t, 16'h0, 1'b0, st, '0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_sel = 2'd0; req_tid = '0;
    req_wdata = '0; req_hv = 1'b0; single_thread = 1'b0; db_set = '0;
    for (int t = 0; t < N; t++) ctrl_m[t] = '0;
    pend_m = '0; fac_m = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(!rsp_valid && !exc_req && db_pending == '0, "R1 reset outputs",
        {29'h0, rsp_valid, exc_req, |db_pending}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R1: all stored state reads zero
    read_all_run(1'b0, "R1 run reset");
    access(1'b0, 2'd2, 0, 16'h0, 1'b0, 1'b0, '0, "R1 fac reset");
    access(1'b0, 2'd1, 0, 16'h0, 1'b1, 1'b0, '0, "R1 db reset");

    // R4: single-thread full store, then R2/R3 must keep unrelated bits
    access(1'b1, 2'd0, 2, 16'hA5A4, 1'b0, 1'b1, '0, "R4 st store");
    read_all_run(1'b1, "R4 st readback");

    // R2 R3 R5: multithread sweep over writer and flag value
    for (int t = 0; t < N; t++) begin
      for (int b = 0; b < 3; b++) begin
        access(1'b1, 2'd0, t, 16'hFFF0 | 16'(b % 2 == 0), 1'b0, 1'b0, '0, "R2 R3 mt write");
        read_all_run(1'b0, "R2 R3 R5 mt readback");
      end
    end
    access(1'b1, 2'd0, 1, 16'h1234, 1'b0, 1'b1, '0, "R4 st store 2");
    read_all_run(1'b0, "R4 others unchanged");

    // R6 R8: exhaustive summary write/read, upper data bits set
    for (int v = 0; v < 16; v++) begin
      access(1'b1, 2'd1, v % N, 16'hFFF0 | 16'(v), 1'b1, 1'b0, '0, "R8 mt db write");
      access(1'b0, 2'd1, (v + 1) % N, 16'h0, 1'b1, 1'b0, '0, "R6 mt db read");
    end

    // R7: single-thread view
    access(1'b1, 2'd1, 0, 16'h000A, 1'b1, 1'b0, '0, "R7 preset");
    for (int t = 0; t < N; t++) begin
      access(1'b0, 2'd1, t, 16'h0, 1'b1, 1'b1, '0, "R7 st read");
      access(1'b1, 2'd1, t, 16'hFFFE | 16'(t % 2 == 0), 1'b1, 1'b1, '0, "R7 st write");
      access(1'b0, 2'd1, t, 16'h0, 1'b1, 1'b1, '0, "R7 st read back");
    end

    // R11: facility word and the unused code
    access(1'b1, 2'd2, 3, 16'h3C00, 1'b0, 1'b0, '0, "R11 fac write");
    access(1'b0, 2'd2, 1, 16'h0, 1'b0, 1'b0, '0, "R11 fac read");
    access(1'b1, 2'd3, 0, 16'hFFFF, 1'b1, 1'b0, '0, "R11 code3 write");
    access(1'b0, 2'd3, 0, 16'h0, 1'b1, 1'b0, '0, "R11 code3 read");
    access(1'b0, 2'd2, 0, 16'h0, 1'b0, 1'b0, '0, "R11 fac unchanged");

    // R9 R12: refused write, refused read, then allowed by enable bit
    access(1'b1, 2'd1, 2, 16'h000F, 1'b0, 1'b0, '0, "R9 denied write");
    idle_check("R9 after deny");
    access(1'b0, 2'd2, 0, 16'h0, 1'b0, 1'b0, '0, "R9 cause cleared");
    access(1'b0, 2'd1, 1, 16'h0, 1'b0, 1'b0, '0, "R9 denied read");
    access(1'b0, 2'd1, 1, 16'h0, 1'b0, 1'b1, '0, "R9 denied st read");
    idle_check("R12 single pulse");
    access(1'b1, 2'd2, 0, 16'h7701, 1'b1, 1'b0, '0, "R9 enable");
    access(1'b1, 2'd1, 3, 16'h0009, 1'b0, 1'b0, '0, "R9 allowed write");
    access(1'b0, 2'd1, 0, 16'h0, 1'b0, 1'b0, '0, "R9 allowed read");

    // R10: arrival against a clearing write, and against a refused one
    access(1'b1, 2'd1, 0, 16'h0000, 1'b1, 1'b0, 4'b0010, "R10 arrival vs clear");
    access(1'b0, 2'd1, 2, 16'h0, 1'b1, 1'b0, '0, "R10 readback");
    access(1'b1, 2'd2, 0, 16'h5500, 1'b1, 1'b0, '0, "R10 disable");
    access(1'b1, 2'd1, 0, 16'h0000, 1'b0, 1'b0, 4'b0100, "R10 arrival vs deny");
    access(1'b0, 2'd1, 0, 16'h0, 1'b1, 1'b0, '0, "R10 readback 2");
    access(1'b0, 2'd0, 0, 16'h0, 1'b0, 1'b0, 4'b1000, "R10 arrival alone");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule